// File: doc/BRIEF.md
# UART Interrupt Aggregation and Control Registers

This block is the register-mapped front end of a UART core for interrupts and control. It turns single-cycle event pulses from the core (receive, transmit, error and timeout conditions) into sticky pending bits. A software-written enable mask gates these bits, and the gated bits are combined into one interrupt request line. Software reads the pending bits either gated or ungated. This lets one service routine find and handle every pending cause. Software acknowledges a cause by writing a one to its position in a write-only acknowledge register.

The same register port holds a control word with two bits. One is the core enable, which software drops while it reprograms the core. The other is a diagnostic loopback. When loopback is set, the core's transmit stream is fed straight back into its receiver. The outgoing pin then sits in the idle mark level and the incoming pin is ignored. Shifters, FIFOs and baud timing live elsewhere. This block only sees their event pulses and their serial bit streams.

Register offsets on `addr`:
- 0: control word.
- 1: enable mask.
- 2: raw pending bits, read-only.
- 3: gated pending bits, read-only.
- 4: acknowledge register, write-only.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset every register reads as zero, `irq` is low, `uart_en` is low and loopback is off.
- R2: A one on `evt_pulse[i]` sets raw pending bit i (offset 2, bit i) at that clock edge. The bit stays set until it is acknowledged, and it reads the same whatever the mask holds.
- R3: Offset 3 reads raw pending ANDed with the mask at offset 1 (mask bit i set means event i is enabled).
- R4: `irq` is the OR of all gated pending bits, registered. It changes one clock after the pending or mask state that causes it.
- R5: Writing offset 4 clears every raw pending bit whose data bit is one, which also clears it in the gated view. Zero data bits leave their pending bits unchanged.
- R6: When an event pulse and an acknowledge of the same bit land in one cycle, the bit stays set.
- R7: Offset 4 and unmapped offsets read zero. Writes to offsets 2 and 3 change nothing.
- R8: Control bit 0 drives `uart_en` and control bit 1 is loopback. Both read back at offset 0.
- R9: With loopback set, `core_rxd` follows `core_txd`, `pin_txd` is held high, and `pin_rxd` has no effect.
- R10: With loopback clear, `pin_txd` follows `core_txd` and `core_rxd` follows `pin_rxd`, combinationally.
- R11: `rdata` loads on the clock edge that samples `rd_en` high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| evt_pulse | input | NUM_EVT | Single-cycle event pulses from the UART core |
| irq | output | 1 | Combined interrupt request |
| uart_en | output | 1 | Core enable from the control word |
| core_txd | input | 1 | Serial stream from the core transmitter |
| core_rxd | output | 1 | Serial stream to the core receiver |
| pin_txd | output | 1 | External transmit pin |
| pin_rxd | input | 1 | External receive pin |

## Verification
The hardest case to reach from the ports is an acknowledge write and a fresh event pulse hitting the same pending bit on the same clock edge. The stimulus drives `wr_en` at offset 4 and `evt_pulse` on the same falling edge. It acknowledges two bits but re-pulses only one of them, so that a single readback shows both outcomes. The one-cycle lag of `irq` is checked by sampling it at the falling edge just after an event lands and again one cycle later.

// File: rtl/uic_pkg.sv
package uic_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_MASK = 3'd1,
        SEL_RAW  = 3'd2,
        SEL_MSKD = 3'd3,
        SEL_ACK  = 3'd4
    } reg_sel_e;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_LB_BIT = 1;

endpackage

// File: rtl/uic_ctrl_regs.sv
module uic_ctrl_regs
    import uic_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_EVT-1:0] wdata_lo,
    output logic               uart_en,
    output logic               loop_en,
    output logic [NUM_EVT-1:0] mask_q
);

    logic hit_ctrl;
    logic hit_mask;

    assign hit_ctrl = wr_en && (addr == ADDR_W'(SEL_CTRL));
    assign hit_mask = wr_en && (addr == ADDR_W'(SEL_MASK));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uart_en <= 1'b0;
            loop_en <= 1'b0;
        end else if (hit_ctrl) begin
            uart_en <= wdata_lo[CTRL_EN_BIT];
            loop_en <= wdata_lo[CTRL_LB_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (hit_mask) begin
            mask_q <= wdata_lo;
        end
    end

endmodule

// File: rtl/uic_status.sv
module uic_status #(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] clr_vec,
    input  logic [NUM_EVT-1:0] mask,
    output logic [NUM_EVT-1:0] raw_q,
    output logic [NUM_EVT-1:0] mskd,
    output logic               irq
);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q[i] <= 1'b0;
            end else if (evt[i]) begin
                raw_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                raw_q[i] <= 1'b0;
            end
        end
    end

    assign mskd = raw_q & mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |mskd;
        end
    end

endmodule

// File: rtl/uic_serial_mux.sv
module uic_serial_mux (
    input  logic loop_en,
    input  logic core_txd,
    input  logic pin_rxd,
    output logic pin_txd,
    output logic core_rxd
);

    always_comb begin
        if (loop_en) begin
            pin_txd  = 1'b1;
            core_rxd = core_txd;
        end else begin
            pin_txd  = core_txd;
            core_rxd = pin_rxd;
        end
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uic_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq,
    output logic               uart_en,
    input  logic               core_txd,
    output logic               core_rxd,
    output logic               pin_txd,
    input  logic               pin_rxd
);

    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] raw_q;
    logic [NUM_EVT-1:0] mskd;
    logic [NUM_EVT-1:0] clr_vec;
    logic               loop_en;
    logic [DATA_W-1:0]  rd_nxt;

    if (DATA_W > NUM_EVT) begin : g_hi
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_EVT];
    end

    assign clr_vec = (wr_en && (addr == ADDR_W'(SEL_ACK))) ? wdata[NUM_EVT-1:0] : '0;

    uic_ctrl_regs #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata_lo (wdata[NUM_EVT-1:0]),
        .uart_en  (uart_en),
        .loop_en  (loop_en),
        .mask_q   (mask_q)
    );

    uic_status #(.NUM_EVT(NUM_EVT)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_pulse),
        .clr_vec (clr_vec),
        .mask    (mask_q),
        .raw_q   (raw_q),
        .mskd    (mskd),
        .irq     (irq)
    );

    uic_serial_mux u_mux (
        .loop_en  (loop_en),
        .core_txd (core_txd),
        .pin_rxd  (pin_rxd),
        .pin_txd  (pin_txd),
        .core_rxd (core_rxd)
    );

    always_comb begin
        rd_nxt = '0;
        unique case (addr)
            ADDR_W'(SEL_CTRL): begin
                rd_nxt[CTRL_EN_BIT] = uart_en;
                rd_nxt[CTRL_LB_BIT] = loop_en;
            end
            ADDR_W'(SEL_MASK): rd_nxt[NUM_EVT-1:0] = mask_q;
            ADDR_W'(SEL_RAW):  rd_nxt[NUM_EVT-1:0] = raw_q;
            ADDR_W'(SEL_MSKD): rd_nxt[NUM_EVT-1:0] = mskd;
            default:           rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_nxt;
        end
    end

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
    parameter int NUM_EVT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt,
    input logic [NUM_EVT-1:0] clr_vec,
    input logic [NUM_EVT-1:0] raw,
    input logic [NUM_EVT-1:0] mask,
    input logic               irq,
    input logic               lb,
    input logic               core_txd,
    input logic               core_rxd,
    input logic               pin_txd
);

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw) & ~raw & ~$past(clr_vec)) == '0)); // R2
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw & $past(evt)) == $past(evt))); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~evt)) |=> ((raw & $past(clr_vec & ~evt)) == '0)); // R5
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(raw & mask)))); // R4
    AST_LOOP_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        lb |-> pin_txd); // R9
    AST_LOOP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        lb |-> (core_rxd == core_txd)); // R9

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .clr_vec  (clr_vec),
    .raw      (raw_q),
    .mask     (mask_q),
    .irq      (irq),
    .lb       (loop_en),
    .core_txd (core_txd),
    .core_rxd (core_rxd),
    .pin_txd  (pin_txd)
);

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;

    localparam int NE = 8;
    localparam int DW = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NE-1:0] evt_pulse = '0;
    logic          irq;
    logic          uart_en;
    logic          core_txd = 1'b1;
    logic          core_rxd;
    logic          pin_txd;
    logic          pin_rxd = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ctrl #(.NUM_EVT(NE), .DATA_W(DW), .ADDR_W(AW)) i_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .irq(irq),
        .uart_en(uart_en), .core_txd(core_txd), .core_rxd(core_rxd),
        .pin_txd(pin_txd), .pin_rxd(pin_rxd)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [NE-1:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1 irq", DW'(irq), 0);
        chk("R1 uart_en", DW'(uart_en), 0);
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd1, v); chk("R1 mask", v, 0);
        rd(3'd2, v); chk("R1 raw", v, 0);
        core_txd = 1'b0; pin_rxd = 1'b0; #1;
        chk("R10 pin_txd", DW'(pin_txd), 0);
        chk("R10 core_rxd", DW'(core_rxd), 0);
        core_txd = 1'b1; pin_rxd = 1'b1; #1;
        chk("R10 pin_txd high", DW'(pin_txd), 1);
    endtask

    task automatic t_unmasked();
        logic [DW-1:0] v;
        pulse(8'h05);
        rd(3'd2, v); chk("R2 raw set", v, 32'h05);
        rd(3'd3, v); chk("R3 gated zero", v, 0);
        chk("R4 irq masked off", DW'(irq), 0);
        pulse(8'h00);
        rd(3'd2, v); chk("R2 raw sticky", v, 32'h05);
    endtask

    task automatic t_mask_irq();
        logic [DW-1:0] v;
        wr(3'd4, 32'hFF);
        wr(3'd1, 32'h04);
        @(negedge clk);
        chk("R4 irq idle", DW'(irq), 0);
        pulse(8'h04);
        chk("R4 irq one-cycle lag", DW'(irq), 0);
        @(negedge clk);
        chk("R4 irq raised", DW'(irq), 1);
        rd(3'd3, v); chk("R3 gated", v, 32'h04);
        rd(3'd2, v); chk("R2 raw with mask", v, 32'h04);
    endtask

    task automatic t_clear();
        logic [DW-1:0] v;
        pulse(8'h03);
        wr(3'd4, 32'h00);
        rd(3'd2, v); chk("R5 zero ack no effect", v, 32'h07);
        wr(3'd4, 32'h02);
        rd(3'd2, v); chk("R5 raw after ack", v, 32'h05);
        rd(3'd3, v); chk("R5 gated after ack", v, 32'h04);
        chk("R4 irq still high", DW'(irq), 1);
        wr(3'd4, 32'h04);
        rd(3'd3, v); chk("R5 gated cleared", v, 0);
        chk("R4 irq dropped", DW'(irq), 0);
    endtask

    task automatic t_collide();
        logic [DW-1:0] v;
        pulse(8'h08);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd4; wdata = 32'h09; evt_pulse = 8'h08;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; evt_pulse = '0;
        rd(3'd2, v); chk("R6 event beats ack", v, 32'h08);
    endtask

    task automatic t_readonly();
        logic [DW-1:0] v;
        wr(3'd2, 32'hFF);
        wr(3'd3, 32'hFF);
        rd(3'd2, v); chk("R7 raw write ignored", v, 32'h08);
        rd(3'd1, v); chk("R7 mask untouched", v, 32'h04);
        rd(3'd4, v); chk("R7 ack reads zero", v, 0);
        rd(3'd7, v); chk("R7 unmapped reads zero", v, 0);
    endtask

    task automatic t_hold();
        logic [DW-1:0] v;
        rd(3'd1, v); chk("R11 read mask", v, 32'h04);
        @(negedge clk); addr = 3'd2;
        @(negedge clk);
        chk("R11 rdata held", rdata, 32'h04);
    endtask

    task automatic t_ctrl_loop();
        logic [DW-1:0] v;
        wr(3'd0, 32'h1);
        chk("R8 uart_en set", DW'(uart_en), 1);
        rd(3'd0, v); chk("R8 ctrl readback", v, 32'h1);
        wr(3'd0, 32'h3);
        rd(3'd0, v); chk("R8 loopback readback", v, 32'h3);
        core_txd = 1'b0; pin_rxd = 1'b1; #1;
        chk("R9 pin idles high", DW'(pin_txd), 1);
        chk("R9 rx follows tx", DW'(core_rxd), 0);
        pin_rxd = 1'b0; core_txd = 1'b1; #1;
        chk("R9 pin_rxd ignored", DW'(core_rxd), 1);
        wr(3'd0, 32'h1);
        core_txd = 1'b0; pin_rxd = 1'b1; #1;
        chk("R10 pin_txd normal", DW'(pin_txd), 0);
        chk("R10 core_rxd normal", DW'(core_rxd), 1);
        wr(3'd0, 32'h0);
        chk("R8 uart_en cleared", DW'(uart_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unmasked();
        t_mask_irq();
        t_clear();
        t_collide();
        t_readonly();
        t_hold();
        t_ctrl_loop();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule